// File: doc/BRIEF.md
# I/O Port Trap Checker

This block decides whether a guest port I/O access must be intercepted. A request carries a 16-bit start port, an access size of one, two or four bytes, and two policy controls: an unconditional-exit control and a bitmap-mode control. The block answers with a one-cycle `done` pulse, an `trap_exit` verdict and a `size_err` flag. The verdict and the flag stay valid until the next request is accepted.

Policy rules:
- With both controls clear, the verdict is always "no exit".
- With only the unconditional control set, every access exits.
- In bitmap mode the unconditional control is ignored. The verdict then comes from a 65536-bit permission bitmap, one bit per port. The bitmap is held in two internal 4096-byte banks and is loaded through a byte-wide write port.
- An access that runs past the top of the port space exits at once in bitmap mode, without reading the bitmap.

The controller is a four-state machine:
- `ST_IDLE` waits for `start`.
- `ST_PROBE` issues the first bitmap read.
- `ST_SCAN` tests one port bit per cycle while it issues the next read.
- `ST_FINISH` pulses `done`.

The transitions are:
- **accept-immediate**: `ST_IDLE`→`ST_FINISH`. Taken for a bad size, for a non-bitmap request, or for a wrapping request in bitmap mode.
- **accept-lookup**: `ST_IDLE`→`ST_PROBE`. Taken for any other request.
- **first-read**: `ST_PROBE`→`ST_SCAN`.
- **next-port**: `ST_SCAN`→`ST_SCAN`. Taken while the tested bit is clear and ports remain.
- **hit-or-last**: `ST_SCAN`→`ST_FINISH`.
- **release**: `ST_FINISH`→`ST_IDLE`.

Bitmap writes are held off while a lookup is in progress.

Top module: `io_trap_checker`

## Requirements
- R1: With `ctl_bitmap`=0 and `ctl_uncond`=0, a request with a valid size completes with `trap_exit`=0.
- R2: With `ctl_bitmap`=0 and `ctl_uncond`=1, a request with a valid size completes with `trap_exit`=1.
- R3: With `ctl_bitmap`=1, the value of `ctl_uncond` has no effect. A non-wrapping request exits if and only if at least one covered port has its bitmap bit at 1.
- R4: A request covers ports `port_in` through `port_in`+N-1, where N is 1, 2 or 4. For a bitmap lookup with no set bit, `done` rises in cycle N+2 after the accepting edge, which is one port per cycle. A set bit ends the lookup early with `trap_exit`=1.
- R5: With `ctl_bitmap`=1, a request whose last port would pass FFFFh exits regardless of bitmap contents. A request that ends exactly at FFFFh does not wrap.
- R6: Port bits are laid out as follows:
  - Bit `port[15]` selects the bank: 0 selects bank A (`wr_bank`=0) and 1 selects bank B (`wr_bank`=1).
  - Within the selected bank, the byte address is `port[14:3]` and the bit within that byte is `port[2:0]`.
  - A bit in one bank never affects a port mapped to the other bank.
- R7: `size_in` is coded as follows: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Code 3 completes in the cycle after acceptance with `size_err`=1 and `trap_exit`=0, whatever the controls are.
- R8: Each accepted request produces exactly one single-cycle `done` pulse. `start` is accepted only while `busy`=0. A `start` seen while busy is ignored and does not alter the pending verdict.
- R9: While a lookup is in progress and `done` is low, `wr_ready` is 0 and a held `wr_en` is not applied to the bitmap. The write takes effect once `wr_ready` returns to 1.
- R10: After reset, `busy`, `done`, `trap_exit` and `size_err` are 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted only while idle |
| ctl_uncond | input | 1 | Unconditional-exit control |
| ctl_bitmap | input | 1 | Bitmap-mode control |
| port_in | input | 16 | First port of the access |
| size_in | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2: 4 bytes) |
| busy | output | 1 | Request in progress (includes the `done` cycle) |
| done | output | 1 | One-cycle completion pulse |
| trap_exit | output | 1 | Verdict: the access must exit |
| size_err | output | 1 | Request used the reserved size code |
| wr_en | input | 1 | Bitmap byte write request, held until accepted |
| wr_bank | input | 1 | Bank select for the write (0: A, 1: B) |
| wr_addr | input | 12 | Byte address within the bank |
| wr_data | input | 8 | Byte to store |
| wr_ready | output | 1 | Write is accepted on this edge when `wr_en` is high |

## Verification
Some properties hold on every cycle, and the assertions track these against controls they capture themselves at acceptance:
- the fixed verdicts of the two non-bitmap policies;
- the forced exit on a wrapping bitmap request;
- the reserved size code;
- the single-cycle `done` pulse;
- the closed write port during a lookup.

Other behaviour depends on bitmap contents and only the bench scenarios can show it:
- which ports a multi-byte access actually covers;
- the split between the two banks at port 8000h;
- early termination on a hit;
- the exact completion cycle;
- that a stalled write lands after, and not during, the lookup it waited on.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_SCAN   = 2'd2,
        ST_FINISH = 2'd3
    } trap_state_e;

    localparam logic [1:0] SIZE_BYTE  = 2'd0;
    localparam logic [1:0] SIZE_WORD  = 2'd1;
    localparam logic [1:0] SIZE_DWORD = 2'd2;
    localparam logic [1:0] SIZE_RSVD  = 2'd3;

endpackage

// File: rtl/io_access_decode.sv
module io_access_decode #(
    parameter int PORT_W    = 16,
    parameter int MAX_BYTES = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size,
    output logic [CNT_W-1:0]  len,
    output logic              size_bad,
    output logic              wraps
);
    import io_trap_pkg::*;

    logic [PORT_W:0] last_port;

    always_comb begin
        size_bad = 1'b0;
        unique case (size)
            SIZE_BYTE:  len = CNT_W'(1);
            SIZE_WORD:  len = CNT_W'(2);
            SIZE_DWORD: len = CNT_W'(4);
            default: begin
                len      = '0;
                size_bad = 1'b1;
            end
        endcase
    end

    // Extended-width end port: a carry into the top bit means the access
    // runs past the highest port.
    always_comb begin
        last_port = {1'b0, port} + {{(PORT_W + 1 - CNT_W){1'b0}}, len} - (PORT_W + 1)'(1);
        wraps     = !size_bad && last_port[PORT_W];
    end

endmodule

// File: rtl/io_bitmap_bank.sv
module io_bitmap_bank #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/io_bitmap_store.sv
module io_bitmap_store #(
    parameter int PORT_W  = 16,
    parameter int BYTE_W  = 8,
    localparam int BIT_W  = $clog2(BYTE_W),
    localparam int ADDR_W = PORT_W - 1 - BIT_W,
    localparam int BANKS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [PORT_W-1:0] rd_port,
    output logic              rd_bit
);
    logic [BYTE_W-1:0] bank_byte [BANKS];
    logic              sel_q;
    logic [BIT_W-1:0]  bit_q;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        io_bitmap_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (BYTE_W)
        ) u_bank (
            .clk     (clk),
            .wr_en   (wr_en && (wr_bank == 1'(g))),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (rd_port[PORT_W-2:BIT_W]),
            .rd_data (bank_byte[g])
        );
    end

    // Bank select and bit position follow the registered byte read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            bit_q <= '0;
        end else begin
            sel_q <= rd_port[PORT_W-1];
            bit_q <= rd_port[BIT_W-1:0];
        end
    end

    assign rd_bit = bank_byte[sel_q][bit_q];

endmodule

// File: rtl/io_trap_checker.sv
module io_trap_checker #(
    parameter int PORT_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   ctl_uncond,
    input  logic                                   ctl_bitmap,
    input  logic [PORT_W-1:0]                      port_in,
    input  logic [1:0]                             size_in,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   trap_exit,
    output logic                                   size_err,
    input  logic                                   wr_en,
    input  logic                                   wr_bank,
    input  logic [PORT_W-2-$clog2(BYTE_W):0]       wr_addr,
    input  logic [BYTE_W-1:0]                      wr_data,
    output logic                                   wr_ready
);
    import io_trap_pkg::*;

    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    trap_state_e       state_q, state_d;
    logic [PORT_W-1:0] base_q;
    logic [CNT_W-1:0]  len_q, cnt_q;
    logic              exit_q, err_q;

    logic [CNT_W-1:0]  dec_len;
    logic              dec_bad, dec_wraps;
    logic [PORT_W-1:0] rd_port;
    logic              rd_bit;
    logic              accept, immediate, last_port;

    io_access_decode #(
        .PORT_W    (PORT_W),
        .MAX_BYTES (MAX_BYTES)
    ) u_decode (
        .port     (port_in),
        .size     (size_in),
        .len      (dec_len),
        .size_bad (dec_bad),
        .wraps    (dec_wraps)
    );

    assign rd_port = base_q + PORT_W'(cnt_q);

    io_bitmap_store #(
        .PORT_W (PORT_W),
        .BYTE_W (BYTE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && wr_ready),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_port (rd_port),
        .rd_bit  (rd_bit)
    );

    assign accept    = (state_q == ST_IDLE) && start;
    assign immediate = dec_bad || !ctl_bitmap || dec_wraps;
    assign last_port = (cnt_q == len_q);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = immediate ? ST_FINISH : ST_PROBE;
            ST_PROBE:  state_d = ST_SCAN;
            ST_SCAN:   if (rd_bit || last_port) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request context and verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            cnt_q  <= '0;
            exit_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        base_q <= port_in;
                        len_q  <= dec_len;
                        cnt_q  <= '0;
                        err_q  <= dec_bad;
                        exit_q <= dec_bad    ? 1'b0 :
                                  ctl_bitmap ? dec_wraps : ctl_uncond;
                    end
                end
                ST_PROBE: cnt_q <= cnt_q + CNT_W'(1);
                ST_SCAN: begin
                    if (rd_bit) begin
                        exit_q <= 1'b1;
                    end else if (!last_port) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_FINISH: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        wr_ready  = (state_q == ST_IDLE) || (state_q == ST_FINISH);
        trap_exit = exit_q;
        size_err  = err_q;
    end

endmodule

// File: rtl/io_trap_checker_sva.sv
module io_trap_checker_sva #(
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ctl_uncond,
    input logic              ctl_bitmap,
    input logic [PORT_W-1:0] port_in,
    input logic [1:0]        size_in,
    input logic              busy,
    input logic              done,
    input logic              trap_exit,
    input logic              size_err,
    input logic              wr_ready
);
    logic              cap_u, cap_b, cap_rsvd, cap_wrap;
    logic [PORT_W:0]   span_end;
    logic [2:0]        nbytes;

    always_comb begin
        case (size_in)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            2'd2:    nbytes = 3'd4;
            default: nbytes = 3'd1;
        endcase
        span_end = {1'b0, port_in} + (PORT_W + 1)'(nbytes);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_u    <= 1'b0;
            cap_b    <= 1'b0;
            cap_rsvd <= 1'b0;
            cap_wrap <= 1'b0;
        end else if (start && !busy) begin
            cap_u    <= ctl_uncond;
            cap_b    <= ctl_bitmap;
            cap_rsvd <= (size_in == 2'd3);
            cap_wrap <= (span_end > (PORT_W + 1)'(1 << PORT_W));
        end
    end

    p_off_no_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cap_b && !cap_u && !cap_rsvd |-> !trap_exit);

    p_uncond_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cap_b && cap_u && !cap_rsvd |-> trap_exit);

    p_wrap_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_b && cap_wrap && !cap_rsvd |-> trap_exit);

    p_bad_size_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && cap_rsvd |-> size_err && !trap_exit);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_write_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |-> !wr_ready);

endmodule

bind io_trap_checker io_trap_checker_sva #(.PORT_W(PORT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ctl_uncond (ctl_uncond),
    .ctl_bitmap (ctl_bitmap),
    .port_in    (port_in),
    .size_in    (size_in),
    .busy       (busy),
    .done       (done),
    .trap_exit  (trap_exit),
    .size_err   (size_err),
    .wr_ready   (wr_ready)
);

// File: tb/io_trap_checker_test.sv
module io_trap_checker_test;

    localparam int WATCHDOG = 150000;

    typedef struct packed {
        logic        u;
        logic        b;
        logic [15:0] port;
        logic [1:0]  size;
        logic        exp_exit;
        logic        exp_err;
    } vec_t;

    // Bits set in the bitmap: ports 0043h, 7FFFh (bank A), 8005h, FFF0h (bank B)
    localparam int NVEC = 20;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 16'h0043, 2'd0, 1'b0, 1'b0},  // R1
        '{1'b0, 1'b0, 16'hFFFE, 2'd2, 1'b0, 1'b0},  // R1 (wrap ignored)
        '{1'b1, 1'b0, 16'h1000, 2'd2, 1'b1, 1'b0},  // R2
        '{1'b1, 1'b0, 16'hFFFF, 2'd2, 1'b1, 1'b0},  // R2
        '{1'b0, 1'b1, 16'h0043, 2'd0, 1'b1, 1'b0},  // R3
        '{1'b1, 1'b1, 16'h0044, 2'd0, 1'b0, 1'b0},  // R3 uncond ignored
        '{1'b1, 1'b1, 16'h0043, 2'd0, 1'b1, 1'b0},  // R3
        '{1'b0, 1'b1, 16'h0040, 2'd2, 1'b1, 1'b0},  // R4 last covered port
        '{1'b0, 1'b1, 16'h0042, 2'd1, 1'b1, 1'b0},  // R4
        '{1'b0, 1'b1, 16'h0044, 2'd2, 1'b0, 1'b0},  // R4 just above
        '{1'b0, 1'b1, 16'h0041, 2'd1, 1'b0, 1'b0},  // R4 just below
        '{1'b0, 1'b1, 16'h7FFE, 2'd1, 1'b1, 1'b0},  // R6 bank A top
        '{1'b0, 1'b1, 16'h8003, 2'd2, 1'b1, 1'b0},  // R6 bank B
        '{1'b0, 1'b1, 16'h0005, 2'd0, 1'b0, 1'b0},  // R6 bank separation
        '{1'b0, 1'b1, 16'hFFFF, 2'd0, 1'b0, 1'b0},  // R5 no wrap
        '{1'b0, 1'b1, 16'hFFFC, 2'd2, 1'b0, 1'b0},  // R5 ends at FFFFh
        '{1'b0, 1'b1, 16'hFFFF, 2'd1, 1'b1, 1'b0},  // R5 wrap
        '{1'b0, 1'b1, 16'hFFFD, 2'd2, 1'b1, 1'b0},  // R5 wrap
        '{1'b0, 1'b1, 16'h0000, 2'd3, 1'b0, 1'b1},  // R7
        '{1'b1, 1'b0, 16'hFFFF, 2'd3, 1'b0, 1'b1}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, ctl_uncond = 1'b0, ctl_bitmap = 1'b0;
    logic [15:0] port_in = '0;
    logic [1:0]  size_in = '0;
    logic        busy, done, trap_exit, size_err, wr_ready;
    logic        wr_en = 1'b0, wr_bank = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;

    int checks = 0;
    int errors = 0;
    logic timed_out = 1'b0;

    always #2.5 clk = ~clk;

    io_trap_checker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctl_uncond(ctl_uncond),
        .ctl_bitmap(ctl_bitmap), .port_in(port_in), .size_in(size_in),
        .busy(busy), .done(done), .trap_exit(trap_exit), .size_err(size_err),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready)
    );

    task automatic check(input logic ok, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic write_byte(input logic bank, input logic [11:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = bank; wr_addr = addr; wr_data = data;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue one request, watch 12 cycles, return done count, verdict and latency.
    task automatic issue(input logic u, input logic b, input logic [15:0] p, input logic [1:0] s,
                         output int ndone, output logic gx, output logic ge, output int lat);
        ndone = 0; gx = 1'b0; ge = 1'b0; lat = 0;
        @(negedge clk);
        start = 1'b1; ctl_uncond = u; ctl_bitmap = b; port_in = p; size_in = s;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            if (done) begin
                ndone++; gx = trap_exit; ge = size_err;
                if (lat == 0) lat = i;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_all();
        int nd, lat;
        logic gx, ge;

        // R10: reset state
        #1;
        check(busy == 1'b0, "R10 busy", int'(busy), 0);
        check(done == 1'b0, "R10 done", int'(done), 0);
        check(trap_exit == 1'b0, "R10 trap_exit", int'(trap_exit), 0);
        check(size_err == 1'b0, "R10 size_err", int'(size_err), 0);
        check(wr_ready == 1'b1, "R10 wr_ready", int'(wr_ready), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int bk = 0; bk < 2; bk++)
            for (int a = 0; a < 4096; a++)
                write_byte(1'(bk), 12'(a), 8'h00);
        write_byte(1'b0, 12'h008, 8'h08);  // port 0043h
        write_byte(1'b0, 12'hFFF, 8'h80);  // port 7FFFh
        write_byte(1'b1, 12'h000, 8'h20);  // port 8005h
        write_byte(1'b1, 12'hFFE, 8'h01);  // port FFF0h

        for (int v = 0; v < NVEC; v++) begin
            issue(VECS[v].u, VECS[v].b, VECS[v].port, VECS[v].size, nd, gx, ge, lat);
            check(nd == 1, $sformatf("R8 done count vec %0d", v), nd, 1);
            check(gx == VECS[v].exp_exit, $sformatf("R1-5 verdict vec %0d port %0h", v, VECS[v].port),
                  int'(gx), int'(VECS[v].exp_exit));
            check(ge == VECS[v].exp_err, $sformatf("R7 size_err vec %0d", v), int'(ge), int'(VECS[v].exp_err));
        end

        // R4: timing of bitmap scans, one port per cycle
        issue(1'b0, 1'b1, 16'h0100, 2'd2, nd, gx, ge, lat);
        check(lat == 6, "R4 latency 4-byte miss", lat, 6);
        issue(1'b0, 1'b1, 16'h0100, 2'd0, nd, gx, ge, lat);
        check(lat == 3, "R4 latency 1-byte miss", lat, 3);
        issue(1'b0, 1'b1, 16'h0043, 2'd2, nd, gx, ge, lat);
        check(lat == 3 && gx, "R4 early hit on first port", lat, 3);
        issue(1'b1, 1'b0, 16'h0100, 2'd2, nd, gx, ge, lat);
        check(lat == 1, "R2 immediate latency", lat, 1);

        // R8: start while busy is ignored
        begin
            int ndn = 0;
            logic x = 1'b0, e = 1'b0;
            @(negedge clk);
            start = 1'b1; ctl_uncond = 1'b0; ctl_bitmap = 1'b1; port_in = 16'h0040; size_in = 2'd2;
            @(negedge clk);
            start = 1'b1; ctl_uncond = 1'b1; ctl_bitmap = 1'b0; port_in = 16'h0000; size_in = 2'd3;
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 12; i++) begin
                if (done) begin ndn++; x = trap_exit; e = size_err; end
                @(negedge clk);
            end
            check(ndn == 1, "R8 single done with busy start", ndn, 1);
            check(x == 1'b1 && e == 1'b0, "R8 busy start ignored", int'({x, e}), 2);
        end

        // R9: write stalled during lookup
        begin
            int ndn = 0;
            logic x = 1'b1;
            logic stalled_seen = 1'b0;
            logic accepted = 1'b0;
            @(negedge clk);
            start = 1'b1; ctl_uncond = 1'b0; ctl_bitmap = 1'b1; port_in = 16'h0050; size_in = 2'd2;
            @(negedge clk);
            start = 1'b0;
            wr_en = 1'b1; wr_bank = 1'b0; wr_addr = 12'h00A; wr_data = 8'h01;  // port 0050h
            check(wr_ready == 1'b0, "R9 wr_ready low during lookup", int'(wr_ready), 0);
            for (int i = 0; i < 12; i++) begin
                if (done) begin ndn++; x = trap_exit; end
                if (!wr_ready) stalled_seen = 1'b1;
                if (wr_en && wr_ready) accepted = 1'b1;
                @(negedge clk);
                if (accepted) wr_en = 1'b0;
            end
            check(stalled_seen && accepted, "R9 write held then accepted", int'({stalled_seen, accepted}), 3);
            check(ndn == 1 && x == 1'b0, "R9 stalled write not seen by lookup", int'(x), 0);
            issue(1'b0, 1'b1, 16'h0050, 2'd0, nd, gx, ge, lat);
            check(gx == 1'b1, "R9 write applied after lookup", int'(gx), 1);
            issue(1'b0, 1'b1, 16'h8050, 2'd0, nd, gx, ge, lat);
            check(gx == 1'b0, "R6 bank A write not visible in bank B", int'(gx), 0);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (WATCHDOG) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule